// File: doc/BRIEF.md
# Dual-Port Interprocessor Mailbox

This block lets two processors pass 32-bit messages to each other through eight one-way channels. Each channel owns a four-word message queue. The direction of each channel comes from two control bits. One processor writes words into a channel's data register, and the other processor reads them out in the same order. Both processors reach the block through one shared register bus. A round-robin arbiter serves exactly one access per cycle, and read data returns one cycle after the grant.

Each processor has its own interrupt enable register, its own interrupt status register and a level interrupt line. A receive event is raised for the processor on the receiving side when a channel's queue goes from empty to holding data. A transmit event is raised for the processor on the sending side when the queue goes from full to having room. Status bits are cleared by writing one. A receive bit will not clear while its queue still holds data. Either processor may read both status registers, so a sender can poll the receiver's receive bit to learn that its message has been drained.

Top module: `ipc_mailbox`

## Requirements
- R1: When both users request in the same cycle, the user that was not served most recently gets the grant (user 0 goes first after reset). At most one grant is high in a cycle, and only to a requesting user.
- R2: A granted read returns its data on `bus_rdata[u]` with `bus_rvalid[u]` high in the cycle after the grant.
- R3: The channel data register at byte offset 0x180+4n queues words written by the sender and returns them in first-in, first-out order to the receiver's reads.
- R4: Each queue holds 4 words. A push into a full queue is dropped. A pop from an empty queue returns zero and leaves the count unchanged.
- R5: Offset 0x140+4n reads the channel's word count in bits [2:0]. Offset 0x100+4n reads 1 in bit 0 when the channel's queue is full.
- R6: Control word k at offset 4k covers channels 4k..4k+3. For channel n, bit 8(n mod 4) is the receive bit and bit 8(n mod 4)+4 is the send bit, and both read back as written. With only the send bit set, user 0 sends and user 1 receives. With only the receive bit set, user 1 sends and user 0 receives. With neither or both set, the channel is inactive.
- R7: A data write by the receiving user, a data read by the sending user, and any data access to an inactive channel leave the queue unchanged. A read of this kind returns zero.
- R8: User 0 has its enable register at 0x40 and its status register at 0x50; user 1 has 0x60 and 0x70. Channel n uses bit 2n for receive and bit 2n+1 for transmit. The receive bit sets when the queue becomes non-empty for the receiving user. The transmit bit sets when the channel becomes not-full for the sending user, and this includes the moment the direction is configured.
- R9: Writing 1 to a status bit clears it. A clear of a receive bit has no effect while that channel's queue is non-empty.
- R10: Either user can read both status registers.
- R11: `irq[u]` is the registered OR of user u's status bits ANDed with its enable bits.
- R12: After reset, all queues are empty, all direction, enable and status bits are zero, and `irq` and `bus_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 2 | Access request, one bit per user |
| bus_we | input | 2 | Write enable, one bit per user |
| bus_addr | input | 2x9 | Byte address, one per user |
| bus_wdata | input | 2x32 | Write data, one per user |
| bus_gnt | output | 2 | Access served this cycle |
| bus_rvalid | output | 2 | Read data valid (one cycle after grant) |
| bus_rdata | output | 2x32 | Read data, one per user |
| irq | output | 2 | Level interrupt, one per user |

## Verification
The bench targets the refused receive clear. A design that ignored the rule would drop the receive bit while a word is still queued, and the sender's poll of that bit would report the message as consumed too early. It pushes a fifth word into a full queue and pops from an empty one; a design wrong here would overwrite data or return stale words. It makes accesses against the configured direction and to inactive channels; a design that honoured them would corrupt the queue count. It raises simultaneous requests right after a lone user-0 access, to catch an arbiter that starves the other user. It also checks an interrupt line while its status bit is set but not enabled, to catch a line that ignores the enable mask.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned OFS_EN0 = 32'h040;
  localparam int unsigned OFS_ST0 = 32'h050;
  localparam int unsigned OFS_EN1 = 32'h060;
  localparam int unsigned OFS_ST1 = 32'h070;
  localparam int unsigned OFS_FST = 32'h100;
  localparam int unsigned OFS_MST = 32'h140;
  localparam int unsigned OFS_DAT = 32'h180;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRL, RG_EN, RG_STAT, RG_FSTAT, RG_MSTAT, RG_DATA
  } reg_kind_e;
endpackage

// File: rtl/mbox_arb.sv
module mbox_arb (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req,
  output logic [1:0] gnt,
  output logic       win
);
  logic last_q;

  always_comb begin
    win = (req == 2'b11) ? ~last_q : req[1];
    gnt = (req == 2'b00) ? 2'b00 : (win ? 2'b10 : 2'b01);
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else if (|req) last_q <= win;
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  a_r1_only_req: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == 2'b00);
  a_r1_rotate: assert property (@(posedge clk) disable iff (rst)
    (req == 2'b11 && gnt[0]) |=> (req != 2'b11 || gnt[1]));
endmodule

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic [DW-1:0]              din,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH));
  a_r4_full_drop: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(cnt));
  a_r4_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> $stable(cnt));
endmodule

// File: rtl/mbox_irqstat.sv
module mbox_irqstat #(
  parameter int NCH  = 8,
  parameter int USER = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   active,
  input  logic [NCH-1:0]   snd_is1,
  input  logic [NCH-1:0]   empty,
  input  logic [NCH-1:0]   full,
  input  logic             clr_we,
  input  logic [2*NCH-1:0] clr_mask,
  output logic [2*NCH-1:0] stat
);
  localparam int SW = 2*NCH;
  localparam bit ME = (USER != 0);

  logic [SW-1:0] cond, cond_q, clr_ok;

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      cond[2*n]     = active[n] && (snd_is1[n] != ME) && !empty[n];
      cond[2*n+1]   = active[n] && (snd_is1[n] == ME) && !full[n];
      clr_ok[2*n]   = clr_we && clr_mask[2*n] && empty[n];
      clr_ok[2*n+1] = clr_we && clr_mask[2*n+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= '0;
      stat   <= '0;
    end else begin
      cond_q <= cond;
      stat   <= (stat & ~clr_ok) | (cond & ~cond_q);
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    a_r9_rx_hold: assert property (@(posedge clk) disable iff (rst)
      (stat[2*n] && !empty[n]) |=> stat[2*n]);
    a_r8_rx_set: assert property (@(posedge clk) disable iff (rst)
      (cond[2*n] && !cond_q[2*n]) |=> stat[2*n]);
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  parameter int AW    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          bus_req,
  input  logic [1:0]          bus_we,
  input  logic [1:0][AW-1:0]  bus_addr,
  input  logic [1:0][DW-1:0]  bus_wdata,
  output logic [1:0]          bus_gnt,
  output logic [1:0]          bus_rvalid,
  output logic [1:0][DW-1:0]  bus_rdata,
  output logic [1:0]          irq
);
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CW    = $clog2(DEPTH+1);
  localparam int NCTRL = (NCH + 3) / 4;
  localparam int CIW   = (NCTRL > 1) ? $clog2(NCTRL) : 1;
  localparam int SW    = 2*NCH;

  logic            usr, acc, w, side;
  logic [AW-1:0]   a;
  logic [31:0]     a32;
  logic [DW-1:0]   wd, rval;
  reg_kind_e       kind;
  logic [CHW-1:0]  chn;
  logic [CIW-1:0]  cidx;

  logic [NCH-1:0]  dir_rx, dir_tx, active, snd_is1;
  logic [NCH-1:0]  push, pop, full, empty;
  logic [DW-1:0]   head [NCH];
  logic [CW-1:0]   cnt  [NCH];
  logic [1:0][SW-1:0] en_q;
  logic [SW-1:0]   stat [2];

  mbox_arb u_arb (.clk(clk), .rst(rst), .req(bus_req), .gnt(bus_gnt), .win(usr));

  assign acc     = |bus_gnt;
  assign a       = bus_addr[usr];
  assign w       = bus_we[usr];
  assign wd      = bus_wdata[usr];
  assign a32     = 32'(a);
  assign chn     = a[2 +: CHW];
  assign cidx    = a[2 +: CIW];
  assign active  = dir_rx ^ dir_tx;
  assign snd_is1 = dir_rx;

  always_comb begin
    side = 1'b0;
    kind = RG_NONE;
    if (a32 < 32'(4*NCTRL))                                 kind = RG_CTRL;
    else if (a32 == OFS_EN0 || a32 == OFS_EN1) begin        kind = RG_EN;   side = (a32 == OFS_EN1); end
    else if (a32 == OFS_ST0 || a32 == OFS_ST1) begin        kind = RG_STAT; side = (a32 == OFS_ST1); end
    else if (a32 >= OFS_FST && a32 < OFS_FST + 32'(4*NCH))  kind = RG_FSTAT;
    else if (a32 >= OFS_MST && a32 < OFS_MST + 32'(4*NCH))  kind = RG_MSTAT;
    else if (a32 >= OFS_DAT && a32 < OFS_DAT + 32'(4*NCH))  kind = RG_DATA;
  end

  always_comb begin
    push = '0;
    pop  = '0;
    for (int n = 0; n < NCH; n++) begin
      if (acc && kind == RG_DATA && chn == CHW'(n) && active[n]) begin
        if (w && snd_is1[n] == usr)  push[n] = 1'b1;
        if (!w && snd_is1[n] != usr) pop[n]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_rx <= '0;
      dir_tx <= '0;
      en_q   <= '0;
    end else if (acc && w) begin
      if (kind == RG_CTRL) begin
        for (int n = 0; n < NCH; n++) begin
          if (CIW'(n/4) == cidx) begin
            dir_rx[n] <= wd[8*(n%4)];
            dir_tx[n] <= wd[8*(n%4)+4];
          end
        end
      end
      if (kind == RG_EN) en_q[side] <= wd[SW-1:0];
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    mbox_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(push[n]), .pop(pop[n]), .din(wd),
      .head(head[n]), .cnt(cnt[n]), .full(full[n]), .empty(empty[n]));
  end

  for (genvar u = 0; u < 2; u++) begin : g_usr
    mbox_irqstat #(.NCH(NCH), .USER(u)) u_stat (
      .clk(clk), .rst(rst), .active(active), .snd_is1(snd_is1),
      .empty(empty), .full(full),
      .clr_we(acc && w && kind == RG_STAT && side == 1'(u)),
      .clr_mask(wd[SW-1:0]), .stat(stat[u]));
  end

  always_comb begin
    rval = '0;
    case (kind)
      RG_CTRL: begin
        for (int n = 0; n < NCH; n++) begin
          if (CIW'(n/4) == cidx) begin
            rval[8*(n%4)]   = dir_rx[n];
            rval[8*(n%4)+4] = dir_tx[n];
          end
        end
      end
      RG_EN:    rval[SW-1:0] = en_q[side];
      RG_STAT:  rval[SW-1:0] = stat[side];
      RG_FSTAT: rval[0]      = full[chn];
      RG_MSTAT: rval[CW-1:0] = cnt[chn];
      RG_DATA:  if (|pop && !empty[chn]) rval = head[chn];
      default:  rval = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= '0;
      bus_rdata  <= '0;
      irq        <= '0;
    end else begin
      for (int u = 0; u < 2; u++) begin
        bus_rvalid[u] <= bus_gnt[u] && !bus_we[u];
        if (bus_gnt[u] && !bus_we[u]) bus_rdata[u] <= rval;
        irq[u] <= |(stat[u] & en_q[u]);
      end
    end
  end

  a_r7_recv_push_ignored: assert property (@(posedge clk) disable iff (rst)
    (acc && w && kind == RG_DATA && active[chn] && snd_is1[chn] != usr)
      |=> (cnt[$past(chn)] == $past(cnt[chn])));
  for (genvar u = 0; u < 2; u++) begin : g_irqchk
    a_r11_masked_low: assert property (@(posedge clk) disable iff (rst)
      ((stat[u] & en_q[u]) == '0) |=> !irq[u]);
  end
endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]        req = '0, we = '0;
  logic [1:0][8:0]   addr = '0;
  logic [1:0][31:0]  wdata = '0;
  logic [1:0]        gnt, rvalid, irq;
  logic [1:0][31:0]  rdata;

  int n_chk = 0, n_err = 0, cyc = 0;
  int gcyc [2];
  bit done = 0;
  logic [31:0] q0 [$], q1 [$];
  string t0 [$], t1 [$];

  ipc_mailbox uut (.clk(clk), .rst(rst), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_gnt(gnt), .bus_rvalid(rvalid), .bus_rdata(rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input int u, input bit w, input logic [8:0] ad, input logic [31:0] d,
                        input logic [31:0] e, input string tag);
    repeat (3) @(negedge clk);
    req[u] = 1'b1; we[u] = w; addr[u] = ad; wdata[u] = d;
    #1;
    while (!gnt[u]) begin @(negedge clk); #1; end
    gcyc[u] = cyc;
    if (!w) begin
      if (u == 0) begin q0.push_back(e); t0.push_back(tag); end
      else        begin q1.push_back(e); t1.push_back(tag); end
    end
    @(posedge clk); #1;
    req[u] = 1'b0;
    if (!w) begin
      @(negedge clk);
      chk(32'(rvalid[u]), 32'd1, {"R2 rvalid ", tag});
    end
  endtask

  task automatic wr(input int u, input logic [8:0] ad, input logic [31:0] d);
    access(u, 1'b1, ad, d, 32'h0, "");
  endtask

  task automatic rd(input int u, input logic [8:0] ad, input logic [31:0] e, input string tag);
    access(u, 1'b0, ad, 32'h0, e, tag);
  endtask

  // monitor: scoreboard compare of returned read data
  always @(negedge clk) begin
    if (!rst) begin
      for (int u = 0; u < 2; u++) begin
        if (rvalid[u]) begin
          if ((u == 0 && q0.size() == 0) || (u == 1 && q1.size() == 0)) begin
            n_chk++; n_err++;
            $display("FAIL R2 unexpected read data user %0d actual %h expected none", u, rdata[u]);
          end else if (u == 0) chk(rdata[0], q0.pop_front(), t0.pop_front());
          else                 chk(rdata[1], q1.pop_front(), t1.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(32'(irq), 32'd0, "R12 irq after reset");
    chk(32'(rvalid), 32'd0, "R12 rvalid after reset");
    rst = 1'b0;
    rd(0, 9'h000, 32'h0, "R12 ctrl0 zero");
    rd(1, 9'h050, 32'h0, "R12 stat0 zero");
    rd(0, 9'h040, 32'h0, "R12 en0 zero");
    rd(1, 9'h140, 32'h0, "R12 ch0 empty");

    // ch0: user0 sends; ch1: user1 sends; ch4: both bits -> inactive
    wr(0, 9'h000, 32'h0000_0110);
    wr(0, 9'h004, 32'h0000_0011);
    rd(0, 9'h000, 32'h0000_0110, "R6 ctrl0 readback");
    rd(1, 9'h004, 32'h0000_0011, "R6 ctrl1 readback");
    rd(0, 9'h050, 32'h2, "R8 user0 tx bit on config");
    rd(0, 9'h070, 32'h8, "R8 user1 tx bit on config");

    wr(1, 9'h060, 32'h1);
    for (int i = 0; i < 5; i++) wr(0, 9'h180, 32'hA000_0000 + i);
    rd(1, 9'h140, 32'd4, "R5 ch0 count");
    rd(1, 9'h100, 32'd1, "R5 ch0 full flag");
    rd(1, 9'h104, 32'd0, "R5 ch1 not full");
    rd(1, 9'h070, 32'h9, "R8 rx bit set");
    repeat (2) @(negedge clk);
    chk(32'(irq), 32'h2, "R11 irq1 high, irq0 masked");

    wr(0, 9'h050, 32'h2);
    rd(0, 9'h050, 32'h0, "R9 tx bit cleared");

    wr(1, 9'h180, 32'hDEAD_BEEF);
    rd(0, 9'h180, 32'h0, "R7 sender pop returns zero");
    rd(0, 9'h140, 32'd4, "R7 wrong-direction count kept");
    wr(0, 9'h190, 32'h55);
    wr(1, 9'h190, 32'h66);
    rd(1, 9'h150, 32'd0, "R7 inactive channel untouched");

    wr(1, 9'h070, 32'h1);
    rd(1, 9'h070, 32'h9, "R9 rx clear refused");
    rd(0, 9'h070, 32'h9, "R10 cross read");

    for (int i = 0; i < 4; i++) rd(1, 9'h180, 32'hA000_0000 + i, "R3 fifo order");
    rd(1, 9'h180, 32'h0, "R4 empty pop zero");
    rd(1, 9'h140, 32'd0, "R4 count after empty pop");
    rd(0, 9'h050, 32'h2, "R8 tx bit on leaving full");

    wr(1, 9'h070, 32'h1);
    rd(0, 9'h070, 32'h8, "R9 rx clear after drain");
    repeat (2) @(negedge clk);
    chk(32'(irq), 32'h0, "R11 irq1 low");

    rd(0, 9'h144, 32'd0, "R5 ch1 count");
    fork
      rd(0, 9'h144, 32'd0, "R1 both user0");
      rd(1, 9'h144, 32'd0, "R1 both user1");
    join
    chk(32'(gcyc[1] < gcyc[0]), 32'd1, "R1 user1 first after user0");
    chk(32'(gcyc[1] != gcyc[0]), 32'd1, "R1 one grant per cycle");

    wr(1, 9'h184, 32'h0000_00B0);
    rd(0, 9'h050, 32'h6, "R8 ch1 rx for user0");
    repeat (2) @(negedge clk);
    chk(32'(irq[0]), 32'd0, "R11 irq0 masked");
    rd(0, 9'h184, 32'h0000_00B0, "R3 ch1 word");
    wr(0, 9'h050, 32'h4);
    rd(0, 9'h050, 32'h2, "R9 rx clear when empty");

    repeat (5) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule